// File: doc/BRIEF.md
# Dual-Table Register Rename Unit

This block turns architectural register names into physical register tags for an out-of-order core. A small set of architectural registers is mapped onto a much larger pool of physical registers. Each renamed destination gets a fresh physical tag, which removes write-after-write and write-after-read dependences. Read-after-write dependences are kept, because later sources look up the newest mapping.

Two alias tables are kept. The speculative table is read and written at rename time. The committed table changes only when a micro-op retires. Retiring moves no register data, since results already live in the physical file. Instead, the committed table takes the retiring tag and the tag it replaces goes back to the free pool. On a flush, the committed table is copied into the speculative table and the free pool is rebuilt as every tag the committed table does not hold. The physical register file and wakeup logic sit outside the block.

Top module: `reg_rename_dual`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both tables, and physical registers NUM_ARCH to NUM_PHYS-1 are free, so the first destination tag offered is NUM_ARCH.
- R2: Both source tags are read from the speculative table as it stood before the current micro-op. A source that names the same register as that micro-op's destination receives the previous mapping.
- R3: A destination receives the lowest-numbered free physical register, shown on `ren_pdst`. `ren_pold` returns the speculative mapping that the destination replaces. Later micro-ops reading that register see the new tag.
- R4: A micro-op with `ren_has_dst` low consumes no physical register and leaves the speculative table unchanged.
- R5: When no physical register is free, `ren_ready` is low for a micro-op with a destination, and neither table nor pool changes. A micro-op without a destination stays accepted.
- R6: A retire event writes `ret_pdst` into the committed entry for `ret_arch` and returns that entry's previous tag to the free pool.
- R7: While `flush` is high, `ren_ready` is low. On that edge the speculative table becomes a copy of the committed table, and the pool becomes exactly the tags the committed table does not hold.
- R8: A retire event alone does not alter any speculative mapping.
- R9: A retire event in the same cycle as a flush is applied to the committed table before that table is copied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard speculative state and restore from committed table |
| ren_valid | input | 1 | Rename request present |
| ren_has_dst | input | 1 | Request writes a destination register |
| ren_src_a | input | AW | First source architectural register |
| ren_src_b | input | AW | Second source architectural register |
| ren_dst | input | AW | Destination architectural register |
| ren_ready | output | 1 | Request accepted this cycle |
| ren_psrc_a | output | PW | Physical tag of first source |
| ren_psrc_b | output | PW | Physical tag of second source |
| ren_pdst | output | PW | Physical tag assigned to the destination (lowest free) |
| ren_pold | output | PW | Previous speculative mapping of the destination |
| ret_valid | input | 1 | A micro-op with a destination retires |
| ret_arch | input | AW | Architectural destination of the retiring micro-op |
| ret_pdst | input | PW | Physical tag the retiring micro-op wrote |

## Verification
The bench runs a reference model of both tables and the pool. It renames through every architectural register, often with a source equal to the destination. A design that wrote the table before reading would hand the new tag to that source. The bench drains the pool completely to check the stall. A unit that allocated anyway would return a tag still in use. Retirement is driven in order and then checked through speculative lookups and tag reuse. A unit that freed the retiring tag, rather than the one it replaces, would give out a live register. The bench also issues a flush in the same cycle as a retirement. A copy taken from the stale committed table would lose the last committed mapping and leak one tag from the pool.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS = 8;
  localparam int PHYS_REGS = 128;
endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int N = 8,
  parameter int W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [$clog2(N)-1:0] wr_idx,
  input  logic [W-1:0]   wr_val,
  input  logic           load_en,
  input  logic [N*W-1:0] load_flat,
  output logic [N*W-1:0] flat
);
  logic [N*W-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) tbl_q[i*W +: W] <= W'(i);
    end else if (load_en) begin
      tbl_q <= load_flat;
    end else if (wr_en) begin
      tbl_q[int'(wr_idx)*W +: W] <= wr_val;
    end
  end

  assign flat = tbl_q;
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
  parameter int N        = 128,
  parameter int RESERVED = 8,
  localparam int W       = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic         rel_en,
  input  logic [W-1:0] rel_idx,
  input  logic         rebuild_en,
  input  logic [N-1:0] used_mask,
  output logic         avail,
  output logic [W-1:0] alloc_idx,
  output logic [N-1:0] free_vec
);
  function automatic logic [W-1:0] lowest_free(input logic [N-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = W'(i);
    return r;
  endfunction

  logic [N-1:0] free_q, free_d;

  assign avail     = |free_q;
  assign alloc_idx = lowest_free(free_q);
  assign free_vec  = free_q;

  always_comb begin
    free_d = free_q;
    if (alloc_en) free_d[alloc_idx] = 1'b0;
    if (rel_en)   free_d[rel_idx]   = 1'b1;
    if (rebuild_en) free_d = ~used_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) free_q[i] <= (i >= RESERVED);
    end else begin
      free_q <= free_d;
    end
  end

  // R3
  alloc_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> free_q[alloc_idx]);

  // R6
  no_double_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> !free_q[rel_idx]);
endmodule

// File: rtl/reg_rename_dual.sv
module reg_rename_dual
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = ARCH_REGS,
  parameter int NUM_PHYS = PHYS_REGS,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int TW = NUM_ARCH * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ren_valid,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic [PW-1:0] ren_psrc_a,
  output logic [PW-1:0] ren_psrc_b,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          ret_valid,
  input  logic [AW-1:0] ret_arch,
  input  logic [PW-1:0] ret_pdst
);
  function automatic logic [PW-1:0] tbl_read(input logic [TW-1:0] t, input logic [AW-1:0] idx);
    return t[int'(idx)*PW +: PW];
  endfunction

  function automatic logic [TW-1:0] tbl_patch(input logic [TW-1:0] t, input logic [AW-1:0] idx,
                                              input logic [PW-1:0] val);
    logic [TW-1:0] r;
    r = t;
    r[int'(idx)*PW +: PW] = val;
    return r;
  endfunction

  logic [TW-1:0]       spec_flat, comm_flat, comm_next;
  logic [NUM_PHYS-1:0] used_mask, pool_free;
  logic                pool_avail, ren_fire, alloc_fire;
  logic [PW-1:0]       pool_pick, comm_old;

  // acceptance and events
  assign ren_ready  = !flush && (!ren_has_dst || pool_avail);
  assign ren_fire   = ren_valid && ren_ready;
  assign alloc_fire = ren_fire && ren_has_dst;

  // lookups before this micro-op's write
  assign ren_psrc_a = tbl_read(spec_flat, ren_src_a);
  assign ren_psrc_b = tbl_read(spec_flat, ren_src_b);
  assign ren_pold   = tbl_read(spec_flat, ren_dst);
  assign ren_pdst   = pool_pick;

  // committed view including a same-cycle retirement
  assign comm_old  = tbl_read(comm_flat, ret_arch);
  assign comm_next = ret_valid ? tbl_patch(comm_flat, ret_arch, ret_pdst) : comm_flat;

  always_comb begin
    used_mask = '0;
    for (int i = 0; i < NUM_ARCH; i++) used_mask[comm_next[i*PW +: PW]] = 1'b1;
  end

  rn_alias_table #(.N(NUM_ARCH), .W(PW)) u_spec_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(alloc_fire), .wr_idx(ren_dst), .wr_val(pool_pick),
    .load_en(flush), .load_flat(comm_next),
    .flat(spec_flat)
  );

  rn_alias_table #(.N(NUM_ARCH), .W(PW)) u_comm_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ret_valid), .wr_idx(ret_arch), .wr_val(ret_pdst),
    .load_en(1'b0), .load_flat({TW{1'b0}}),
    .flat(comm_flat)
  );

  rn_free_pool #(.N(NUM_PHYS), .RESERVED(NUM_ARCH)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire),
    .rel_en(ret_valid), .rel_idx(comm_old),
    .rebuild_en(flush), .used_mask(used_mask),
    .avail(pool_avail), .alloc_idx(pool_pick), .free_vec(pool_free)
  );

  // R5
  stall_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_has_dst && pool_free == '0) |-> !ren_ready);

  // R7
  flush_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (spec_flat == comm_flat));

  // R7
  flush_pool_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(pool_free) == NUM_PHYS - NUM_ARCH));

  // R8
  retire_spec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !flush && !alloc_fire) |=> $stable(spec_flat));
endmodule

// File: tb/test_reg_rename_dual.sv
`timescale 1ns/1ps
module test_reg_rename_dual;
  localparam int NA = 8;
  localparam int NP = 128;

  logic clk = 0, rst_n = 0, flush = 0;
  logic ren_valid = 0, ren_has_dst = 0;
  logic [2:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0;
  logic ren_ready;
  logic [6:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;
  logic ret_valid = 0;
  logic [2:0] ret_arch = 0;
  logic [6:0] ret_pdst = 0;

  always #2.5 clk = ~clk;

  reg_rename_dual i_reg_rename_dual (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
    .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
    .ren_ready(ren_ready), .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b),
    .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_pdst(ret_pdst)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  int spec_m[NA], comm_m[NA];
  bit [NP-1:0] free_m;
  int q_arch[1024], q_phys[1024];
  int q_head = 0, q_tail = 0;

  function automatic int lowest(input bit [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rename(input int sa, input int sb, input bit hd, input int d, input string tag);
    int lo;
    bit rdy;
    @(negedge clk);
    ren_valid = 1; ren_has_dst = hd;
    ren_src_a = 3'(sa); ren_src_b = 3'(sb); ren_dst = 3'(d);
    #1;
    lo  = lowest(free_m);
    rdy = !hd || (lo >= 0);
    chk("R5 ready", int'(ren_ready), int'(rdy));
    if (rdy) begin
      chk({tag, " src_a"}, int'(ren_psrc_a), spec_m[sa]);
      chk({tag, " src_b"}, int'(ren_psrc_b), spec_m[sb]);
      if (hd) begin
        chk("R3 pdst", int'(ren_pdst), lo);
        chk("R3 pold", int'(ren_pold), spec_m[d]);
      end
    end
    @(posedge clk);
    #1 ren_valid = 0;
    if (rdy && hd) begin
      spec_m[d] = lo; free_m[lo] = 0;
      q_arch[q_tail] = d; q_phys[q_tail] = lo; q_tail++;
    end
  endtask

  task automatic retire_flush(input bit do_ret, input bit do_fl);
    @(negedge clk);
    if (do_ret) begin
      ret_valid = 1; ret_arch = 3'(q_arch[q_head]); ret_pdst = 7'(q_phys[q_head]);
    end
    flush = do_fl;
    if (do_fl) begin
      ren_valid = 1; ren_has_dst = 0;
      #1 chk("R7 ready in flush", int'(ren_ready), 0);
    end
    @(posedge clk);
    #1 ret_valid = 0; flush = 0; ren_valid = 0;
    if (do_ret) begin
      free_m[comm_m[q_arch[q_head]]] = 1;
      comm_m[q_arch[q_head]] = q_phys[q_head];
      q_head++;
    end
    if (do_fl) begin
      free_m = '1;
      for (int i = 0; i < NA; i++) begin
        spec_m[i] = comm_m[i];
        free_m[comm_m[i]] = 0;
      end
      q_head = q_tail;
    end
  endtask

  task automatic probe(input string tag);
    for (int a = 0; a < NA; a++) rename(a, (a + 3) % NA, 0, a, tag);
  endtask

  task automatic peek_pdst(input string tag);
    @(negedge clk);
    ren_has_dst = 1; ren_valid = 0;
    #1 chk(tag, int'(ren_pdst), lowest(free_m));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) begin spec_m[i] = i; comm_m[i] = i; end
    free_m = '0;
    for (int i = NA; i < NP; i++) free_m[i] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset mapping and first free tag
    peek_pdst("R1 first free");
    chk("R1 ready", int'(ren_ready), 1);
    probe("R1");

    // R4 no-destination micro-op leaves state alone
    rename(2, 5, 0, 4, "R4");
    peek_pdst("R4 no alloc");
    rename(4, 4, 0, 4, "R4");

    // R2/R3 sweep, source equal to destination
    for (int k = 0; k < 40; k++) rename((k * 3) % NA, k % NA, 1, k % NA, "R2");
    probe("R3 raw");

    // R6/R8 in-order retirement
    for (int k = 0; k < 20; k++) retire_flush(1, 0);
    probe("R8");
    peek_pdst("R6 reuse");
    for (int k = 0; k < 10; k++) rename(k % NA, (k + 1) % NA, 1, (k * 5) % NA, "R6");

    // R5 exhaust the pool
    begin
      int k = 0;
      while (lowest(free_m) >= 0) begin
        rename(k % NA, (k + 2) % NA, 1, (k * 7) % NA, "R2");
        k++;
      end
    end
    rename(1, 2, 1, 3, "R5");
    rename(1, 2, 1, 6, "R5");
    probe("R5 unchanged");

    // R6 retire one, freeing exactly one tag
    retire_flush(1, 0);
    peek_pdst("R6 freed");
    rename(0, 1, 1, 2, "R6");
    rename(0, 1, 1, 5, "R5");

    // R9 flush with same-cycle retire
    retire_flush(1, 1);
    probe("R9");
    peek_pdst("R7 rebuilt pool");

    // R7 plain flush after more renaming
    for (int k = 0; k < 12; k++) rename(k % NA, (k + 4) % NA, 1, (k * 3 + 1) % NA, "R2");
    for (int k = 0; k < 5; k++) retire_flush(1, 0);
    retire_flush(0, 1);
    probe("R7");
    peek_pdst("R7 pool");
    for (int k = 0; k < 6; k++) rename(k % NA, k % NA, 1, k % NA, "R2");
    probe("R3 after flush");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule